// File: doc/BRIEF.md
# Descriptor-Chained Bus-Master Sector DMA Engine

This engine moves the sector data of one disk command between a local sector buffer and host memory without processor involvement. Software prepares a table of 8-byte entries in memory. Each entry names a memory region by its base address and byte count, and a flag marks the last entry. A single start strobe passes the table address. The engine then reads each entry, moves its region, and continues to the next entry until it finishes the flagged one.

Every region is cut into memory requests so that no request crosses a page boundary. When a request is due and the memory port reports busy, the engine waits a fixed number of cycles and then tries again. A direction input sets which way the data moves. When the disk receives data, the engine reads memory. When the disk supplies data, the engine writes memory. When the command ends, the engine updates the status bits and can raise an interrupt. This happens on normal completion and on abort.

Top module: `prd_dma_engine`

## Requirements
- R1: On an accepted `start`, the table pointer is `start_val` with bits 1:0 forced to zero. The first request is a descriptor read (`mem_desc`=1, `mem_we`=0, `mem_len`=8) at that pointer.
- R2: Descriptor read data layout: bits 31:0 are the region base, bits 47:32 are the byte count (bit 32 is ignored and treated as 0; a count of 0 means 65536), and bit 63 marks the last entry. Each later descriptor is read 8 bytes above the previous one.
- R3: A region is moved as data requests. Each request ends at or before the next 4096-byte boundary, the requests together cover exactly the region, and `mem_full_page` is high on a data request only when its length is 4096.
- R4: If `mem_busy` is high when a request is due, no request is raised. The engine waits `BACKOFF_CYC` cycles and then re-tries the same request.
- R5: `bytes_left` is loaded with `cmd_sectors`×512 on start and drops by the length of each completed data request.
- R6: When the region of a last-flagged descriptor completes, `done` pulses for one cycle. `err` is 0 if `bytes_left` is then 0 and 1 otherwise. Without the flag, the next descriptor is fetched.
- R7: With `to_mem`=1 (sampled at start), data requests are memory writes (`mem_we`=1). With `to_mem`=0 they are memory reads. A request stays stable until `mem_done`.
- R8: `bsy` rises on start. At completion or abort, `bsy` clears, `seek` sets, and `intr` is set exactly when `ien_n` is 0. After reset, `bsy`, `seek`, `intr`, `done` and `err` are all 0.
- R9: `abort` while idle has no effect. In any other state, it ends the command in the next cycle with `done` and `err` both 1, and no further requests are raised.
- R10: On each data request, `buf_addr` gives the byte offset in the local buffer, which is the number of bytes already moved in this command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe, accepted only when idle |
| start_val | input | ADDR_W | Table address value; bits 1:0 ignored |
| cmd_sectors | input | SECT_W | Sector count of the command |
| to_mem | input | 1 | 1: data flows to memory; 0: data flows from memory |
| abort | input | 1 | Abort request |
| ien_n | input | 1 | Interrupt disable |
| mem_busy | input | 1 | Memory port busy |
| mem_done | input | 1 | Current request completed |
| mem_rdata | input | 2*ADDR_W | Descriptor read data, valid with mem_done |
| mem_req | output | 1 | Request valid |
| mem_desc | output | 1 | Request is a descriptor read |
| mem_we | output | 1 | Request is a memory write |
| mem_addr | output | ADDR_W | Request address |
| mem_len | output | PAGE_W+1 | Request length in bytes |
| mem_full_page | output | 1 | Data request covers a whole page |
| buf_addr | output | CMD_W | Local buffer byte offset for the request |
| bytes_left | output | CMD_W | Remaining command bytes |
| done | output | 1 | One-cycle end-of-command pulse |
| err | output | 1 | Error flag of the last command |
| bsy | output | 1 | Busy status |
| seek | output | 1 | Seek-complete status |
| intr | output | 1 | Interrupt request |

## Verification
On every cycle, the in-design properties check four things: data requests never run past a page edge, descriptor reads are word-aligned and 8 bytes long, a request only rises after a cycle with the port not busy, and a pending request holds steady. They also check that an idle cycle never produces `done` and that a clean `done` leaves no bytes owed. The bench scenarios show what single-cycle properties cannot. These are the exact chunk counts and full-page counts for regions that start mid-page, descriptor chaining with the pointer stepping by 8, and the byte count held in the ignored count bit. They also cover the error flag on a count mismatch, the length of the busy back-off, the status values after abort, and the buffer offsets across descriptors.

// File: rtl/prd_dma_pkg.sv
package prd_dma_pkg;

    typedef enum logic [2:0] {
        S_IDLE     = 3'd0,
        S_DESC_CHK = 3'd1,
        S_DESC_REQ = 3'd2,
        S_DATA_CHK = 3'd3,
        S_DATA_REQ = 3'd4,
        S_BACKOFF  = 3'd5
    } dma_state_e;

endpackage

// File: rtl/prd_desc_unpack.sv
module prd_desc_unpack #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    localparam int LEFT_W = CNT_W + 1
) (
    input  logic [2*ADDR_W-1:0] word,
    output logic [ADDR_W-1:0]   base,
    output logic [LEFT_W-1:0]   left,
    output logic                last
);
    logic [CNT_W-1:0] cnt_even;
    logic             unused_bits;

    assign base     = word[ADDR_W-1:0];
    // lowest count bit is dropped so regions are whole 16-bit words
    assign cnt_even = {word[ADDR_W+CNT_W-1:ADDR_W+1], 1'b0};
    assign last     = word[2*ADDR_W-1];
    assign unused_bits = ^{word[2*ADDR_W-2:ADDR_W+CNT_W], word[ADDR_W]};

    always_comb begin
        if (cnt_even == '0) begin
            left = LEFT_W'(1) << CNT_W;
        end else begin
            left = LEFT_W'(cnt_even);
        end
    end

endmodule

// File: rtl/prd_page_chunk.sv
module prd_page_chunk #(
    parameter int ADDR_W     = 32,
    parameter int PAGE_BYTES = 4096,
    parameter int LEFT_W     = 17,
    localparam int PAGE_W = $clog2(PAGE_BYTES),
    localparam int LEN_W  = PAGE_W + 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEFT_W-1:0] left,
    output logic [LEN_W-1:0]  len,
    output logic              full
);
    logic [LEN_W-1:0] room;

    assign room = LEN_W'(PAGE_BYTES) - {1'b0, addr[PAGE_W-1:0]};

    always_comb begin
        if (left < LEFT_W'(room)) begin
            len = LEN_W'(left);
        end else begin
            len = room;
        end
        full = (len == LEN_W'(PAGE_BYTES));
    end

endmodule

// File: rtl/prd_backoff.sv
module prd_backoff #(
    parameter int CYCLES = 16,
    localparam int CW = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic clr,
    output logic expired
);
    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } bo_t;

    bo_t b_d, b_q;

    assign expired = b_q.run && (b_q.cnt == '0);

    always_comb begin
        b_d = b_q;
        if (clr) begin
            b_d.run = 1'b0;
        end else if (load) begin
            b_d.run = 1'b1;
            b_d.cnt = CW'(CYCLES - 1);
        end else if (expired) begin
            b_d.run = 1'b0;
        end else if (b_q.run) begin
            b_d.cnt = b_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    // R4: a new wait is never started on top of a running one
    p_no_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !b_q.run);

endmodule

// File: rtl/prd_dma_engine.sv
module prd_dma_engine #(
    parameter int ADDR_W       = 32,
    parameter int PAGE_BYTES   = 4096,
    parameter int CNT_W        = 16,
    parameter int SECT_W       = 9,
    parameter int SECTOR_BYTES = 512,
    parameter int BACKOFF_CYC  = 16,
    localparam int PAGE_W = $clog2(PAGE_BYTES),
    localparam int LEN_W  = PAGE_W + 1,
    localparam int LEFT_W = CNT_W + 1,
    localparam int CMD_W  = SECT_W + $clog2(SECTOR_BYTES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [ADDR_W-1:0]   start_val,
    input  logic [SECT_W-1:0]   cmd_sectors,
    input  logic                to_mem,
    input  logic                abort,
    input  logic                ien_n,
    input  logic                mem_busy,
    input  logic                mem_done,
    input  logic [2*ADDR_W-1:0] mem_rdata,
    output logic                mem_req,
    output logic                mem_desc,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [LEN_W-1:0]    mem_len,
    output logic                mem_full_page,
    output logic [CMD_W-1:0]    buf_addr,
    output logic [CMD_W-1:0]    bytes_left,
    output logic                done,
    output logic                err,
    output logic                bsy,
    output logic                seek,
    output logic                intr
);
    import prd_dma_pkg::*;

    localparam int DESC_BYTES = 8;

    typedef struct packed {
        dma_state_e          st;
        logic [ADDR_W-1:0]   ptr;
        logic [ADDR_W-1:0]   cur;
        logic [LEFT_W-1:0]   left;
        logic                last;
        logic                dir;
        logic                ret_data;
        logic [CMD_W-1:0]    remain;
        logic [CMD_W-1:0]    moved;
        logic                done;
        logic                err;
        logic                bsy;
        logic                seek;
        logic                intr;
    } regs_t;

    regs_t r_d, r_q;

    logic [ADDR_W-1:0] dsc_base;
    logic [LEFT_W-1:0] dsc_left;
    logic              dsc_last;
    logic [LEN_W-1:0]  chunk_len;
    logic              chunk_full;
    logic              bo_load;
    logic              bo_clr;
    logic              bo_expired;
    logic              fin;
    logic              fin_err;
    logic              unused_lo;

    assign unused_lo = ^start_val[1:0];

    prd_desc_unpack #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_unpack (
        .word (mem_rdata),
        .base (dsc_base),
        .left (dsc_left),
        .last (dsc_last)
    );

    prd_page_chunk #(
        .ADDR_W     (ADDR_W),
        .PAGE_BYTES (PAGE_BYTES),
        .LEFT_W     (LEFT_W)
    ) u_chunk (
        .addr (r_q.cur),
        .left (r_q.left),
        .len  (chunk_len),
        .full (chunk_full)
    );

    prd_backoff #(
        .CYCLES (BACKOFF_CYC)
    ) u_backoff (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (bo_load),
        .clr     (bo_clr),
        .expired (bo_expired)
    );

    always_comb begin
        r_d     = r_q;
        r_d.done = 1'b0;
        bo_load = 1'b0;
        bo_clr  = 1'b0;
        fin     = 1'b0;
        fin_err = 1'b0;

        case (r_q.st)
            S_IDLE: begin
                if (start) begin
                    r_d.st     = S_DESC_CHK;
                    r_d.ptr    = {start_val[ADDR_W-1:2], 2'b00};
                    r_d.dir    = to_mem;
                    r_d.remain = CMD_W'(cmd_sectors) * CMD_W'(SECTOR_BYTES);
                    r_d.moved  = '0;
                    r_d.bsy    = 1'b1;
                    r_d.seek   = 1'b0;
                    r_d.intr   = 1'b0;
                    r_d.err    = 1'b0;
                end
            end
            S_DESC_CHK: begin
                if (mem_busy) begin
                    r_d.st       = S_BACKOFF;
                    r_d.ret_data = 1'b0;
                    bo_load      = 1'b1;
                end else begin
                    r_d.st = S_DESC_REQ;
                end
            end
            S_DESC_REQ: begin
                if (mem_done) begin
                    r_d.cur  = dsc_base;
                    r_d.left = dsc_left;
                    r_d.last = dsc_last;
                    r_d.ptr  = r_q.ptr + ADDR_W'(DESC_BYTES);
                    r_d.st   = S_DATA_CHK;
                end
            end
            S_DATA_CHK: begin
                if (mem_busy) begin
                    r_d.st       = S_BACKOFF;
                    r_d.ret_data = 1'b1;
                    bo_load      = 1'b1;
                end else begin
                    r_d.st = S_DATA_REQ;
                end
            end
            S_DATA_REQ: begin
                if (mem_done) begin
                    r_d.cur    = r_q.cur + ADDR_W'(chunk_len);
                    r_d.left   = r_q.left - LEFT_W'(chunk_len);
                    r_d.remain = r_q.remain - CMD_W'(chunk_len);
                    r_d.moved  = r_q.moved + CMD_W'(chunk_len);
                    if (r_q.left == LEFT_W'(chunk_len)) begin
                        if (r_q.last) begin
                            fin     = 1'b1;
                            fin_err = (r_d.remain != '0);
                        end else begin
                            r_d.st = S_DESC_CHK;
                        end
                    end else begin
                        r_d.st = S_DATA_CHK;
                    end
                end
            end
            S_BACKOFF: begin
                if (bo_expired) begin
                    r_d.st = r_q.ret_data ? S_DATA_CHK : S_DESC_CHK;
                end
            end
            default: begin
                r_d.st = S_IDLE;
            end
        endcase

        if (abort && (r_q.st != S_IDLE)) begin
            fin     = 1'b1;
            fin_err = 1'b1;
            bo_clr  = 1'b1;
        end

        if (fin) begin
            r_d.st   = S_IDLE;
            r_d.done = 1'b1;
            r_d.err  = fin_err;
            r_d.bsy  = 1'b0;
            r_d.seek = 1'b1;
            r_d.intr = !ien_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_req       = (r_q.st == S_DESC_REQ) || (r_q.st == S_DATA_REQ);
    assign mem_desc      = (r_q.st == S_DESC_REQ);
    assign mem_we        = (r_q.st == S_DATA_REQ) && r_q.dir;
    assign mem_addr      = mem_desc ? r_q.ptr : r_q.cur;
    assign mem_len       = mem_desc ? LEN_W'(DESC_BYTES) : chunk_len;
    assign mem_full_page = (r_q.st == S_DATA_REQ) && chunk_full;
    assign buf_addr      = r_q.moved;
    assign bytes_left    = r_q.remain;
    assign done          = r_q.done;
    assign err           = r_q.err;
    assign bsy           = r_q.bsy;
    assign seek          = r_q.seek;
    assign intr          = r_q.intr;

    logic [LEN_W:0] req_end;
    assign req_end = {2'b00, mem_addr[PAGE_W-1:0]} + {1'b0, mem_len};

    // R3: a data request stays inside one page
    p_page_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_desc) |-> (req_end <= (LEN_W+1)'(PAGE_BYTES)));

    // R1: descriptor reads are word-aligned and 8 bytes long
    p_desc_shape_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_desc) |-> ((mem_addr[1:0] == 2'b00) && (mem_len == LEN_W'(DESC_BYTES)) && !mem_we));

    // R4: a request only rises after a cycle where the port was free
    p_busy_backoff_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> !$past(mem_busy));

    // R7: a pending request holds still until it completes
    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_done && !abort) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_len)));

    // R8: end of command always shows idle-with-seek status
    p_done_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!bsy && seek));

    // R6: a clean completion leaves nothing owed
    p_clean_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (bytes_left == '0));

    // R9: nothing ends while idle, abort included
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == S_IDLE) && !start) |=> !done);

endmodule

// File: tb/sim_prd_dma_engine.sv
module sim_prd_dma_engine;

    localparam int BO  = 16;
    localparam int LAT = 2;

    typedef struct packed {
        logic [31:0] base;
        logic [15:0] cnt;
        logic [8:0]  sec;
        logic        dir;
        logic [7:0]  nreq;
        logic [7:0]  nfull;
    } vec_t;

    localparam vec_t VECS [0:4] = '{
        '{base: 32'h2000_0000, cnt: 16'h0200, sec: 9'd1,  dir: 1'b1, nreq: 8'd1, nfull: 8'd0},
        '{base: 32'h2000_0F00, cnt: 16'h0400, sec: 9'd2,  dir: 1'b0, nreq: 8'd2, nfull: 8'd0},
        '{base: 32'h3000_0000, cnt: 16'h2000, sec: 9'd16, dir: 1'b1, nreq: 8'd2, nfull: 8'd2},
        '{base: 32'h3000_0800, cnt: 16'h2000, sec: 9'd16, dir: 1'b0, nreq: 8'd3, nfull: 8'd1},
        '{base: 32'h4000_0200, cnt: 16'h0201, sec: 9'd1,  dir: 1'b1, nreq: 8'd1, nfull: 8'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] start_val = '0;
    logic [8:0]  cmd_sectors = '0;
    logic        to_mem = 1'b0;
    logic        abort = 1'b0;
    logic        ien_n = 1'b0;
    logic        mem_busy = 1'b0;
    logic        mem_done = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        mem_req, mem_desc, mem_we, mem_full_page;
    logic [31:0] mem_addr;
    logic [12:0] mem_len;
    logic [17:0] buf_addr, bytes_left;
    logic        done, err, bsy, seek, intr;

    always #10 clk = ~clk;

    prd_dma_engine u0 (
        .clk (clk), .rst_n (rst_n), .start (start), .start_val (start_val),
        .cmd_sectors (cmd_sectors), .to_mem (to_mem), .abort (abort), .ien_n (ien_n),
        .mem_busy (mem_busy), .mem_done (mem_done), .mem_rdata (mem_rdata),
        .mem_req (mem_req), .mem_desc (mem_desc), .mem_we (mem_we),
        .mem_addr (mem_addr), .mem_len (mem_len), .mem_full_page (mem_full_page),
        .buf_addr (buf_addr), .bytes_left (bytes_left),
        .done (done), .err (err), .bsy (bsy), .seek (seek), .intr (intr)
    );

    int checks = 0;
    int failures = 0;

    logic [63:0] desc_mem [0:7];
    logic [31:0] tbl_base = 32'h0001_0004;
    logic        stall = 1'b0;

    int          req_n = 0;
    logic [31:0] lg_addr [0:31];
    logic [12:0] lg_len  [0:31];
    logic        lg_we   [0:31];
    logic        lg_desc [0:31];
    logic        lg_full [0:31];
    logic [17:0] lg_buf  [0:31];
    logic [17:0] lg_left [0:31];

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory responder: logs every new request, answers after LAT cycles
    initial begin
        logic logged;
        logged = 1'b0;
        forever begin
            @(negedge clk);
            if (!mem_req) logged = 1'b0;
            if (mem_req && !logged) begin
                logged = 1'b1;
                if (req_n < 32) begin
                    lg_addr[req_n] = mem_addr;
                    lg_len[req_n]  = mem_len;
                    lg_we[req_n]   = mem_we;
                    lg_desc[req_n] = mem_desc;
                    lg_full[req_n] = mem_full_page;
                    lg_buf[req_n]  = buf_addr;
                    lg_left[req_n] = bytes_left;
                end
                req_n++;
                if (!stall) begin
                    repeat (LAT) @(negedge clk);
                    if (mem_req) begin
                        mem_rdata = mem_desc ? desc_mem[3'((mem_addr - tbl_base) >> 3)] : 64'd0;
                        mem_done  = 1'b1;
                        @(negedge clk);
                        mem_done  = 1'b0;
                    end
                    logged = 1'b0;
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic start_cmd(input logic [31:0] sv, input logic [8:0] sec, input logic dir);
        @(negedge clk);
        req_n       = 0;
        start_val   = sv;
        cmd_sectors = sec;
        to_mem      = dir;
        start       = 1'b1;
        @(negedge clk);
        start       = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        int n;
        n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        seen = done;
    endtask

    initial begin
        bit seen;
        for (int i = 0; i < 8; i++) desc_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state (R8)
        chk("R8 reset bsy", bsy, 0);
        chk("R8 reset seek", seek, 0);
        chk("R8 reset intr", intr, 0);
        chk("R8 reset done/err", {done, err}, 0);
        chk("R5 reset bytes_left", bytes_left, 0);
        chk("R1 reset no request", mem_req, 0);

        // vector table: one last-flagged descriptor each
        for (int v = 0; v < 5; v++) begin
            int   sum;
            int   nfull;
            logic we_ok;
            desc_mem[0] = {1'b1, 15'd0, VECS[v].cnt, VECS[v].base};
            start_cmd(32'h0001_0004 | 32'(v % 4), VECS[v].sec, VECS[v].dir);
            chk("R8 bsy after start", bsy, 1);
            wait_done(seen);
            chk($sformatf("R6 v%0d done", v), seen, 1);
            chk($sformatf("R6 v%0d err", v), err, 0);
            chk($sformatf("R8 v%0d intr/seek/bsy", v), {intr, seek, bsy}, 3'b110);
            chk($sformatf("R5 v%0d bytes_left", v), bytes_left, 0);
            chk($sformatf("R3 v%0d request count", v), req_n, 1 + int'(VECS[v].nreq));
            chk($sformatf("R1 v%0d table addr", v), lg_addr[0], tbl_base);
            chk($sformatf("R7 v%0d descriptor read", v), {lg_desc[0], lg_we[0]}, 2'b10);
            chk($sformatf("R2 v%0d first data addr", v), lg_addr[1], VECS[v].base);
            sum = 0; nfull = 0; we_ok = 1'b1;
            for (int k = 1; k < req_n && k < 32; k++) begin
                sum += int'(lg_len[k]);
                if (lg_full[k]) nfull++;
                if (lg_we[k] != VECS[v].dir) we_ok = 1'b0;
            end
            chk($sformatf("R3 v%0d bytes covered", v), sum, int'(VECS[v].cnt & 16'hFFFE));
            chk($sformatf("R3 v%0d full pages", v), nfull, int'(VECS[v].nfull));
            chk($sformatf("R7 v%0d direction", v), we_ok, 1);
            @(negedge clk);
            chk("R6 done is one pulse", done, 0);
            repeat (5) @(negedge clk);
        end

        // two-entry chain (R2, R5, R10)
        desc_mem[0] = {1'b0, 15'd0, 16'h0200, 32'h5000_0000};
        desc_mem[1] = {1'b1, 15'd0, 16'h0400, 32'h6000_0000};
        start_cmd(tbl_base, 9'd3, 1'b0);
        wait_done(seen);
        chk("R6 chain done", seen, 1);
        chk("R6 chain err", err, 0);
        chk("R2 chain request count", req_n, 4);
        chk("R2 second descriptor addr", lg_addr[2], tbl_base + 32'd8);
        chk("R2 second descriptor is read", lg_desc[2], 1);
        chk("R5 bytes_left after first entry", lg_left[2], 18'd1024);
        chk("R10 buffer offset first", lg_buf[1], 0);
        chk("R10 buffer offset second", lg_buf[3], 18'd512);
        chk("R2 second region addr", lg_addr[3], 32'h6000_0000);
        repeat (5) @(negedge clk);

        // interrupt disabled (R8)
        ien_n = 1'b1;
        desc_mem[0] = {1'b1, 15'd0, 16'h0200, 32'h7000_0000};
        start_cmd(tbl_base, 9'd1, 1'b1);
        wait_done(seen);
        chk("R8 ien_n done", seen, 1);
        chk("R8 ien_n intr/seek/bsy", {intr, seek, bsy}, 3'b010);
        ien_n = 1'b0;
        repeat (3) @(negedge clk);

        // abort while idle is ignored (R9)
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk("R9 idle abort no done", done, 0);
        chk("R9 idle abort no err", err, 0);
        chk("R9 idle abort no request", mem_req, 0);
        repeat (3) @(negedge clk);

        // count mismatch (R6)
        desc_mem[0] = {1'b1, 15'd0, 16'h0200, 32'h7100_0000};
        start_cmd(tbl_base, 9'd2, 1'b1);
        wait_done(seen);
        chk("R6 mismatch done", seen, 1);
        chk("R6 mismatch err", err, 1);
        chk("R5 mismatch bytes_left", bytes_left, 18'd512);
        repeat (5) @(negedge clk);

        // busy port back-off (R4)
        mem_busy = 1'b1;
        start_cmd(tbl_base, 9'd1, 1'b1);
        repeat (40) @(negedge clk);
        chk("R4 no request while busy", req_n, 0);
        mem_busy = 1'b0;
        begin
            int w;
            w = 0;
            while (req_n == 0 && w < 100) begin
                @(negedge clk);
                w++;
            end
            chk("R4 retry within back-off window", (w <= BO + 3) ? 1 : 0, 1);
        end
        chk("R4 retried same descriptor", lg_addr[0], tbl_base);
        wait_done(seen);
        chk("R4 busy run done", {seen, err}, 2'b10);
        repeat (5) @(negedge clk);

        // abort mid-transfer (R9)
        stall = 1'b1;
        start_cmd(tbl_base, 9'd1, 1'b1);
        begin
            int w;
            w = 0;
            while (!mem_req && w < 50) begin
                @(negedge clk);
                w++;
            end
        end
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk("R9 abort done", done, 1);
        chk("R9 abort err", err, 1);
        chk("R8 abort bsy/seek/intr", {bsy, seek, intr}, 3'b011);
        repeat (5) @(negedge clk);
        chk("R9 no request after abort", mem_req, 0);
        stall = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule